// File: doc/BRIEF.md
# Display scan-line address generator

This block turns display timing strobes into DWORD fetch addresses for two buffers held in a graphics aperture of up to 4 MB: the uncompressed frame buffer and the compressed display buffer. Software programs four registers through a simple 32-bit write/read port: the two buffer start offsets, a line delta and a buffer-size word. At each frame start the block loads a line-offset accumulator for each buffer from its start offset. At each line start it steps both accumulators by the line delta, then streams the DWORD addresses of one frame-buffer line.

Panning works because the start offset is split in two. The upper offset bits pass into the active accumulator only at the next frame start. The low four bits leave the block at once as a pixel offset. The block also drives a compression-enable output, which drops whenever a nonzero frame-buffer start is programmed. It raises an invalid flag for the compressed line when the length the compressor reports is larger than the size limit programmed for compressed lines. Offsets are relative to the aperture, and the aperture base is added downstream.

Top module: `scanaddr_gen`

## Requirements
- R1: After reset every register reads zero, no fetch is in progress, the pixel offset is 0, the compressed-line invalid flag is low and compression enable is high.
- R2: Register word select is reg_addr_i[3:2]. Offset 0x00 holds the frame-buffer start in bits [21:0], 0x04 holds the compressed-buffer start, 0x08 holds the line delta, and 0x0C holds the size word in bits [15:0]. Reads are combinational, return the programmed values rather than the active ones, and return zero in every bit above the field.
- R3: Bits [3:0] of the compressed-buffer start always hold zero, and bits [1:0] of the line delta always hold zero, whatever is written.
- R4: Frame-buffer start bits [21:4] reach the line accumulator only at a frame_start_i. A write in the same cycle as frame_start_i leaves the previous value in effect for that frame.
- R5: pixel_ofs_o equals bits [3:0] of the programmed frame-buffer start from the cycle after the write, with no frame delay.
- R6: The first line after frame_start_i begins at the active start offset with bits [3:0] cleared. Each later line_start_i adds the line delta to the previous line offset, modulo 2^22. The compressed buffer has its own accumulator with the same sequence, and its current line offset is shown on cb_line_addr_o.
- R7: In the cycle after line_start_i, fetch_valid_o rises for N consecutive cycles. N is size word bits [8:0], latched at the line start. Beat k shows address line offset + 4k (modulo 2^22) and dword_idx_o = k. N = 0 produces no beat.
- R8: line_done_o is high only together with the final beat of a line.
- R9: A line_start_i during a fetch restarts the fetch with the next line. A frame_start_i ends any fetch. When both strobes arrive in the same cycle, only the frame start acts.
- R10: In the cycle after line_start_i, cb_line_invalid_o becomes (cmp_len_i > size word bits [15:9]). It holds until the next line start, and frame_start_i clears it.
- R11: comp_en_o is low whenever the programmed frame-buffer start is nonzero, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| frame_start_i | input | 1 | Frame scan start strobe |
| line_start_i | input | 1 | Scan-line start strobe |
| cmp_len_i | input | 8 | Length of the current compressed line |
| fetch_valid_o | output | 1 | A frame-buffer fetch beat is present |
| fb_addr_o | output | 22 | Frame-buffer DWORD byte address |
| dword_idx_o | output | 9 | Index of the beat within the line |
| line_done_o | output | 1 | Final beat of the line |
| cb_line_addr_o | output | 22 | Current compressed-buffer line offset |
| cb_line_invalid_o | output | 1 | Compressed line exceeds its size limit |
| pixel_ofs_o | output | 4 | Immediate pixel offset |
| comp_en_o | output | 1 | Compression may be enabled |

## Verification
The address stream is tried with evenly spaced lines under several start and delta values. One start sits near the top of the aperture so that the accumulators wrap, which separates modulo arithmetic from overflow. Line lengths of 0, 1 and longer separate an empty line from a single-beat line, where done coincides with the first beat, and from a normal line. Strobes that arrive mid-line, mid-frame writes and coincident frame and line strobes separate restart, abort and shadowing. A long pseudo-random run mixes all of these against the behavioural model.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [1:0] {
        REG_FB    = 2'd0,
        REG_CB    = 2'd1,
        REG_DELTA = 2'd2,
        REG_SIZE  = 2'd3
    } reg_sel_e;

    localparam int DWORD_BYTES = 4;
    localparam int PIX_BITS    = 4;
    localparam int DW_LSB      = $clog2(DWORD_BYTES);

endpackage

// File: rtl/scan_regs.sv
module scan_regs
    import scan_pkg::*;
#(
    parameter int AW      = 22,
    parameter int FETCH_W = 9,
    parameter int CSIZE_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [3:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic [AW-1:0]      fb_start,
    output logic [AW-1:0]      cb_start,
    output logic [AW-1:0]      delta,
    output logic [FETCH_W-1:0] fetch_len,
    output logic [CSIZE_W-1:0] csize
);

    localparam int SW = FETCH_W + CSIZE_W;

    typedef struct packed {
        logic [AW-1:0] fb;
        logic [AW-1:0] cb;
        logic [AW-1:0] dl;
        logic [SW-1:0] sz;
    } regs_t;

    regs_t r_d, r_q;
    reg_sel_e sel;

    assign sel = reg_sel_e'(addr[3:2]);

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (sel)
                REG_FB:    r_d.fb = wdata[AW-1:0];
                REG_CB:    r_d.cb = {wdata[AW-1:PIX_BITS], {PIX_BITS{1'b0}}};
                REG_DELTA: r_d.dl = {wdata[AW-1:DW_LSB], {DW_LSB{1'b0}}};
                default:   r_d.sz = wdata[SW-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (sel)
            REG_FB:    rdata[AW-1:0] = r_q.fb;
            REG_CB:    rdata[AW-1:0] = r_q.cb;
            REG_DELTA: rdata[AW-1:0] = r_q.dl;
            default:   rdata[SW-1:0] = r_q.sz;
        endcase
    end

    assign fb_start  = r_q.fb;
    assign cb_start  = r_q.cb;
    assign delta     = r_q.dl;
    assign fetch_len = r_q.sz[FETCH_W-1:0];
    assign csize     = r_q.sz[SW-1:FETCH_W];

endmodule

// File: rtl/scan_line_acc.sv
module scan_line_acc #(
    parameter int AW    = 22,
    parameter int ALIGN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          line_start,
    input  logic [AW-1:0] start_ofs,
    input  logic [AW-1:0] delta,
    output logic [AW-1:0] line_ofs,
    output logic [AW-1:0] next_ofs
);

    typedef struct packed {
        logic [AW-1:0] acc;
        logic          first;
    } acc_t;

    acc_t s_d, s_q;

    // offset a line start in this cycle would begin at
    assign next_ofs = s_q.first ? s_q.acc : s_q.acc + delta;

    always_comb begin
        s_d = s_q;
        if (frame_start) begin
            s_d.acc   = {start_ofs[AW-1:ALIGN], {ALIGN{1'b0}}};
            s_d.first = 1'b1;
        end else if (line_start) begin
            s_d.acc   = next_ofs;
            s_d.first = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{acc: '0, first: 1'b1};
        else        s_q <= s_d;
    end

    assign line_ofs = s_q.acc;

endmodule

// File: rtl/scan_fetch.sv
module scan_fetch
    import scan_pkg::*;
#(
    parameter int AW      = 22,
    parameter int FETCH_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               line_start,
    input  logic [AW-1:0]      line_ofs,
    input  logic [FETCH_W-1:0] fetch_len,
    output logic               valid,
    output logic [AW-1:0]      addr,
    output logic [FETCH_W-1:0] idx,
    output logic               done
);

    localparam int CW = FETCH_W + 1;

    typedef struct packed {
        logic               valid;
        logic [AW-1:0]      addr;
        logic [FETCH_W-1:0] idx;
        logic [FETCH_W-1:0] len;
        logic               done;
    } fetch_t;

    fetch_t s_d, s_q;
    logic [CW-1:0] idx_nxt;
    logic [CW-1:0] len_ext;

    assign idx_nxt = {1'b0, s_q.idx} + CW'(1);
    assign len_ext = {1'b0, s_q.len};

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (frame_start) begin
            s_d.valid = 1'b0;
            s_d.idx   = '0;
        end else if (line_start) begin
            s_d.len   = fetch_len;
            s_d.idx   = '0;
            s_d.addr  = line_ofs;
            s_d.valid = (fetch_len != '0);
            s_d.done  = (fetch_len == FETCH_W'(1));
        end else if (s_q.valid) begin
            if (idx_nxt >= len_ext) begin
                s_d.valid = 1'b0;
            end else begin
                s_d.idx  = idx_nxt[FETCH_W-1:0];
                s_d.addr = s_q.addr + AW'(DWORD_BYTES);
                s_d.done = (idx_nxt + CW'(1) == len_ext);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid = s_q.valid;
    assign addr  = s_q.addr;
    assign idx   = s_q.idx;
    assign done  = s_q.done;

endmodule

// File: rtl/scanaddr_gen.sv
module scanaddr_gen
    import scan_pkg::*;
#(
    parameter int AW      = 22,
    parameter int FETCH_W = 9,
    parameter int CSIZE_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we_i,
    input  logic [3:0]         reg_addr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    input  logic               frame_start_i,
    input  logic               line_start_i,
    input  logic [CSIZE_W:0]   cmp_len_i,
    output logic               fetch_valid_o,
    output logic [AW-1:0]      fb_addr_o,
    output logic [FETCH_W-1:0] dword_idx_o,
    output logic               line_done_o,
    output logic [AW-1:0]      cb_line_addr_o,
    output logic               cb_line_invalid_o,
    output logic [PIX_BITS-1:0] pixel_ofs_o,
    output logic               comp_en_o
);

    localparam int NBUF = 2;

    logic [AW-1:0]      fb_start, cb_start, delta;
    logic [FETCH_W-1:0] fetch_len;
    logic [CSIZE_W-1:0] csize;

    logic [AW-1:0] start_arr [NBUF];
    logic [AW-1:0] line_arr  [NBUF];
    logic [AW-1:0] next_arr  [NBUF];

    scan_regs #(.AW(AW), .FETCH_W(FETCH_W), .CSIZE_W(CSIZE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we_i),
        .addr     (reg_addr_i),
        .wdata    (reg_wdata_i),
        .rdata    (reg_rdata_o),
        .fb_start (fb_start),
        .cb_start (cb_start),
        .delta    (delta),
        .fetch_len(fetch_len),
        .csize    (csize)
    );

    assign start_arr[0] = fb_start;
    assign start_arr[1] = cb_start;

    for (genvar g = 0; g < NBUF; g++) begin : g_acc
        scan_line_acc #(.AW(AW), .ALIGN(PIX_BITS)) u_acc (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_start(frame_start_i),
            .line_start (line_start_i),
            .start_ofs  (start_arr[g]),
            .delta      (delta),
            .line_ofs   (line_arr[g]),
            .next_ofs   (next_arr[g])
        );
    end

    scan_fetch #(.AW(AW), .FETCH_W(FETCH_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start_i),
        .line_start (line_start_i),
        .line_ofs   (next_arr[0]),
        .fetch_len  (fetch_len),
        .valid      (fetch_valid_o),
        .addr       (fb_addr_o),
        .idx        (dword_idx_o),
        .done       (line_done_o)
    );

    typedef struct packed {
        logic inval;
    } flag_t;

    flag_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (frame_start_i)     f_d.inval = 1'b0;
        else if (line_start_i) f_d.inval = (cmp_len_i > {1'b0, csize});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign cb_line_addr_o    = line_arr[1];
    assign cb_line_invalid_o = f_q.inval;
    assign pixel_ofs_o       = fb_start[PIX_BITS-1:0];
    assign comp_en_o         = (fb_start == '0);

endmodule

// File: rtl/scanaddr_chk.sv
module scanaddr_chk #(
    parameter int AW      = 22,
    parameter int FETCH_W = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we_i,
    input logic [3:0]         reg_addr_i,
    input logic [31:0]        reg_wdata_i,
    input logic [31:0]        reg_rdata_o,
    input logic               frame_start_i,
    input logic               line_start_i,
    input logic               fetch_valid_o,
    input logic [AW-1:0]      fb_addr_o,
    input logic [FETCH_W-1:0] dword_idx_o,
    input logic               line_done_o,
    input logic               cb_line_invalid_o,
    input logic [3:0]         pixel_ofs_o,
    input logic               comp_en_o
);

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_o && !line_done_o && !line_start_i && !frame_start_i) |=>
        (fetch_valid_o && fb_addr_o == $past(fb_addr_o) + AW'(4)
         && dword_idx_o == $past(dword_idx_o) + FETCH_W'(1)));

    // R8
    done_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done_o |-> fetch_valid_o);

    // R8
    done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_done_o && !line_start_i) |=> !fetch_valid_o);

    // R9
    frame_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> !fetch_valid_o);

    // R5
    pixel_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_addr_i[3:2] == 2'd0) |=> pixel_ofs_o == $past(reg_wdata_i[3:0]));

    // R11
    comp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_addr_i[3:2] == 2'd0 && reg_wdata_i[AW-1:0] != '0) |=> !comp_en_o);

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[31:AW] == '0);

    // R3
    cb_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i[3:2] == 2'd1) |-> reg_rdata_o[3:0] == 4'd0);

    // R10
    inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> !cb_line_invalid_o);

endmodule

bind scanaddr_gen scanaddr_chk #(.AW(AW), .FETCH_W(FETCH_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .reg_we_i         (reg_we_i),
    .reg_addr_i       (reg_addr_i),
    .reg_wdata_i      (reg_wdata_i),
    .reg_rdata_o      (reg_rdata_o),
    .frame_start_i    (frame_start_i),
    .line_start_i     (line_start_i),
    .fetch_valid_o    (fetch_valid_o),
    .fb_addr_o        (fb_addr_o),
    .dword_idx_o      (dword_idx_o),
    .line_done_o      (line_done_o),
    .cb_line_invalid_o(cb_line_invalid_o),
    .pixel_ofs_o      (pixel_ofs_o),
    .comp_en_o        (comp_en_o)
);

// File: tb/scanaddr_gen_bench.sv
module scanaddr_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int unsigned MASK = 32'h003F_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frame_start = 1'b0;
    logic        line_start = 1'b0;
    logic [7:0]  cmp_len = '0;
    logic        fetch_valid;
    logic [21:0] fb_addr;
    logic [8:0]  dword_idx;
    logic        line_done;
    logic [21:0] cb_line_addr;
    logic        cb_inval;
    logic [3:0]  pixel_ofs;
    logic        comp_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    scanaddr_gen u_scanaddr_gen (
        .clk              (clk),
        .rst_n            (rst_n),
        .reg_we_i         (reg_we),
        .reg_addr_i       (reg_addr),
        .reg_wdata_i      (reg_wdata),
        .reg_rdata_o      (reg_rdata),
        .frame_start_i    (frame_start),
        .line_start_i     (line_start),
        .cmp_len_i        (cmp_len),
        .fetch_valid_o    (fetch_valid),
        .fb_addr_o        (fb_addr),
        .dword_idx_o      (dword_idx),
        .line_done_o      (line_done),
        .cb_line_addr_o   (cb_line_addr),
        .cb_line_invalid_o(cb_inval),
        .pixel_ofs_o      (pixel_ofs),
        .comp_en_o        (comp_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int unsigned m_fb, m_cb, m_dl, m_sz;
    int unsigned fb_line, cb_line, n_beats;
    bit          first, inval;
    int unsigned beats[$];

    always @(posedge clk) begin
        int unsigned nf, nc;
        if (!rst_n) begin
            m_fb = 0; m_cb = 0; m_dl = 0; m_sz = 0;
            fb_line = 0; cb_line = 0; n_beats = 0;
            first = 1; inval = 0;
            beats.delete();
        end else begin
            nf = first ? fb_line : (fb_line + m_dl) & MASK;
            nc = first ? cb_line : (cb_line + m_dl) & MASK;
            if (frame_start) begin
                fb_line = m_fb & 32'h003F_FFF0;
                cb_line = m_cb;
                first = 1;
                inval = 0;
                beats.delete();
            end else if (line_start) begin
                fb_line = nf;
                cb_line = nc;
                first = 0;
                beats.delete();
                n_beats = m_sz & 32'h1FF;
                for (int k = 0; k < int'(n_beats); k++)
                    beats.push_back((fb_line + 4 * k) & MASK);
                inval = (cmp_len > ((m_sz >> 9) & 32'h7F));
            end else if (beats.size() > 0) begin
                void'(beats.pop_front());
            end
            if (reg_we) begin
                case (reg_addr[3:2])
                    2'd0: m_fb = reg_wdata & MASK;
                    2'd1: m_cb = reg_wdata & 32'h003F_FFF0;
                    2'd2: m_dl = reg_wdata & 32'h003F_FFFC;
                    default: m_sz = reg_wdata & 32'h0000_FFFF;
                endcase
            end
        end
    end

    function automatic int unsigned exp_rd(input logic [1:0] s);
        case (s)
            2'd0: return m_fb;
            2'd1: return m_cb;
            2'd2: return m_dl;
            default: return m_sz;
        endcase
    endfunction

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R7 fetch_valid", 32'(fetch_valid), 32'(beats.size() > 0));
            if (beats.size() > 0) begin
                chk("R7 R6 fb_addr", 32'(fb_addr), beats[0]);
                chk("R7 dword_idx", 32'(dword_idx), n_beats - beats.size());
                chk("R8 line_done", 32'(line_done), 32'(beats.size() == 1));
            end else begin
                chk("R8 line_done idle", 32'(line_done), 32'd0);
            end
            chk("R6 cb_line_addr", 32'(cb_line_addr), cb_line);
            chk("R10 cb_invalid", 32'(cb_inval), 32'(inval));
            chk("R5 pixel_ofs", 32'(pixel_ofs), m_fb & 15);
            chk("R11 comp_en", 32'(comp_en), 32'(m_fb == 0));
            chk("R2 rdata", reg_rdata, exp_rd(reg_addr[3:2]));
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic frame();
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
    endtask

    task automatic line(input logic [7:0] len, input int gap);
        line_start = 1'b1; cmp_len = len;
        tick();
        line_start = 1'b0;
        idle(gap);
    endtask

    function automatic logic [31:0] sz(input int csz, input int n);
        return 32'((csz << 9) | n);
    endfunction

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    logic [15:0] lfsr = 16'hACE1;

    initial begin
        idle(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 fetch_valid", 32'(fetch_valid), 32'd0);
        chk("R1 pixel_ofs", 32'(pixel_ofs), 32'd0);
        chk("R1 comp_en", 32'(comp_en), 32'd1);
        chk("R1 cb_invalid", 32'(cb_inval), 32'd0);
        chk("R1 rdata", reg_rdata, 32'd0);

        // R2 R3 write all ones, read back masked
        wr(4'h0, 32'hFFFF_FFFF);
        tick();
        chk("R2 fb readback", reg_rdata, 32'h003F_FFFF);
        chk("R11 comp_en low", 32'(comp_en), 32'd0);
        wr(4'h4, 32'hFFFF_FFFF);
        tick();
        chk("R3 cb readback", reg_rdata, 32'h003F_FFF0);
        wr(4'h8, 32'hFFFF_FFFF);
        tick();
        chk("R3 delta readback", reg_rdata, 32'h003F_FFFC);
        wr(4'hC, 32'hFFFF_FFFF);
        tick();
        chk("R2 size readback", reg_rdata, 32'h0000_FFFF);

        // basic frame: pixel offset 5, aligned starts
        wr(4'h0, 32'h0000_1235);
        wr(4'h4, 32'h0002_000F);
        wr(4'h8, 32'h0000_0140);
        wr(4'hC, sz(10, 8));
        frame();
        line(8'd5, 10);
        line(8'd10, 10);
        line(8'd11, 10);
        line(8'd200, 10);

        // R4 mid-frame write does not move lines until next frame
        wr(4'h0, 32'h003F_FF08);
        chk("R5 pixel immediate", 32'(pixel_ofs), 32'd8);
        line(8'd0, 10);
        wr(4'h8, 32'h0000_0100);
        frame();
        line(8'd0, 10);
        line(8'd0, 10);
        line(8'd0, 10);

        // R7 R8 empty and single-beat lines
        wr(4'hC, sz(3, 0));
        line(8'd4, 3);
        wr(4'hC, sz(3, 1));
        line(8'd3, 3);
        line(8'd4, 0);
        line(8'd2, 3);

        // R9 restart mid-line, abort by frame, coincident strobes
        wr(4'hC, sz(20, 20));
        line(8'd1, 3);
        line(8'd1, 5);
        frame();
        line(8'd30, 4);
        frame_start = 1'b1; line_start = 1'b1;
        tick();
        frame_start = 1'b0; line_start = 1'b0;
        // R4 write in same cycle as frame start
        reg_we = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h0001_0000; frame_start = 1'b1;
        tick();
        reg_we = 1'b0; frame_start = 1'b0;
        line(8'd0, 25);
        frame();
        line(8'd0, 25);
        wr(4'h0, 32'h0);
        tick();
        chk("R11 comp_en high", 32'(comp_en), 32'd1);

        // pseudo-random mix
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            frame_start = (lfsr[6:0] == 7'd3);
            line_start  = (lfsr[3:0] == 4'd9) || (lfsr[4:0] == 5'd2);
            cmp_len     = lfsr[15:8];
            reg_we      = (lfsr[9:5] == 5'd7);
            reg_addr    = {lfsr[12:11], 2'b00};
            reg_wdata   = {lfsr, lfsr[7:0], lfsr[15:8]} & 32'hFFFF_F01F;
            tick();
        end
        frame_start = 1'b0; line_start = 1'b0; reg_we = 1'b0;
        idle(40);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule